// File: doc/BRIEF.md
# Source-to-Queue Event Router

The router sits between interrupt sources and a presentation stage. Each incoming event carries only a source number. The block looks that number up in an assignment table. A live entry names a notification descriptor and supplies a data word. The router appends that word to the descriptor's circular event queue, where software later pulls it, and then tells the presenter which target and priority the descriptor stands for.

Every table is an internal register array loaded through one configuration write port. A descriptor that has already notified stays pending until software re-arms it. Events that arrive for a pending descriptor are still queued, but they raise no further notification, so a burst becomes one interrupt. Each queue slot stores a generation bit with its data. Software can therefore tell fresh entries from stale ones without a read pointer in the block.

Software reads the queues through a small combinational read port. Event acceptance is at most one per cycle. A routed event holds the input off for exactly one cycle while its queue slot is written.

Top module: `evq_router`

## Requirements
- R1: After reset `ev_ready` is 1, `ntf_valid` is 0, `drop_cnt` is 0, every queue slot reads 0, and every assignment entry is invalid.
- R2: An event accepted at clock edge k, whose assignment entry is valid and unmasked, produces a notification when its descriptor is not pending. That notification is `ntf_valid` high for exactly the one cycle after edge k+1, carrying the descriptor index, its target and its 3-bit priority (0 most favored).
- R3: The same event writes {generation, data} at edge k+1 into its descriptor's queue at the current write index. Here data is the assignment entry's data word, and the whole value reads back as `rd_entry` = {gen, data[15:0]}.
- R4: Each write advances that descriptor's write index by one. After the last slot (Q_DEPTH-1) the index returns to 0 and the generation bit inverts. The generation bit is 1 after reset and after descriptor programming.
- R5: An event whose assignment entry is invalid or masked is dropped. It increments `drop_cnt` at its acceptance edge, writes no slot, raises no notification, and leaves `ev_ready` high.
- R6: After accepting a routable event, `ev_ready` is 0 for exactly one cycle. An event held on the input during that cycle is not taken, so it produces no second queue write.
- R7: A descriptor becomes pending when it notifies. While it is pending, further events for it are queued with no notification. Configuration kind 2 (re-arm, `cfg_idx[1:0]` = descriptor) clears the pending state.
- R8: A re-arm of a descriptor in the same cycle as a queue write to that descriptor counts before the write. The write therefore notifies, and the descriptor ends up pending.
- R9: Configuration kind 0 loads assignment entry `cfg_idx`: `cfg_data[0]` valid, `[1]` masked, `[3:2]` descriptor, `[19:4]` data. Kind 1 loads descriptor `cfg_idx[1:0]`: `[2:0]` priority, `[10:3]` target. Kind 1 also resets that descriptor's write index to 0, its generation to 1 and its pending state to clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_src | input | 4 | Source number of the offered event |
| ev_ready | output | 1 | Router can take an event this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 assignment, 1 descriptor, 2 re-arm, 3 ignored |
| cfg_idx | input | 4 | Assignment entry or descriptor index |
| cfg_data | input | 20 | Configuration fields |
| ntf_valid | output | 1 | Notification to presenter |
| ntf_desc | output | 2 | Descriptor that notified |
| ntf_target | output | 8 | Target id of that descriptor |
| ntf_prio | output | 3 | Priority of that descriptor |
| rd_desc | input | 2 | Queue read: descriptor |
| rd_slot | input | 2 | Queue read: slot |
| rd_entry | output | 17 | {generation, data} of the addressed slot |
| drop_cnt | output | 8 | Dropped event count, wraps |

## Verification
A queue write and a software re-arm of the same descriptor can fall in the same clock cycle. The bench provokes this by offering an event for a descriptor that is already pending, then driving the re-arm during the single stall cycle that follows acceptance. The bench judges the outcome at the ports. A notification must appear in the next cycle. A later event for the same descriptor must then be coalesced, which shows the pending state ended set.

// File: rtl/evq_router.sv
module evq_router #(
  parameter int SRC_N   = 16,
  parameter int DESC_N  = 4,
  parameter int Q_DEPTH = 4,
  parameter int TGT_W   = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  localparam int SRC_W  = $clog2(SRC_N),
  localparam int DI_W   = $clog2(DESC_N),
  localparam int QI_W   = $clog2(Q_DEPTH),
  localparam int CFG_W  = 2 + DI_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [SRC_W-1:0]  ev_src,
  output logic              ev_ready,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [SRC_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic              ntf_valid,
  output logic [DI_W-1:0]   ntf_desc,
  output logic [TGT_W-1:0]  ntf_target,
  output logic [2:0]        ntf_prio,
  input  logic [DI_W-1:0]   rd_desc,
  input  logic [QI_W-1:0]   rd_slot,
  output logic [DATA_W:0]   rd_entry,
  output logic [CNT_W-1:0]  drop_cnt
);

  logic              as_valid [SRC_N];
  logic              as_mask  [SRC_N];
  logic [DI_W-1:0]   as_desc  [SRC_N];
  logic [DATA_W-1:0] as_data  [SRC_N];

  logic [2:0]        d_prio [DESC_N];
  logic [TGT_W-1:0]  d_tgt  [DESC_N];
  logic [QI_W-1:0]   d_widx [DESC_N];
  logic              d_gen  [DESC_N];
  logic              d_pend [DESC_N];

  logic [DATA_W:0]   qmem [DESC_N*Q_DEPTH];

  logic              busy;
  logic [DI_W-1:0]   w_desc;
  logic [DATA_W-1:0] w_data;

  wire take      = ev_valid && !busy;
  wire routable  = as_valid[ev_src] && !as_mask[ev_src];
  wire cfg_as    = cfg_we && cfg_kind == 2'd0;
  wire cfg_ds    = cfg_we && cfg_kind == 2'd1;
  wire cfg_rearm = cfg_we && cfg_kind == 2'd2;
  wire [DI_W-1:0] cfg_di = cfg_idx[DI_W-1:0];
  wire pend_eff  = d_pend[w_desc] && !(cfg_rearm && cfg_di == w_desc);
  wire last_slot = d_widx[w_desc] == QI_W'(Q_DEPTH - 1);

  assign ev_ready = !busy;
  assign rd_entry = qmem[{rd_desc, rd_slot}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      w_desc     <= '0;
      w_data     <= '0;
      ntf_valid  <= 1'b0;
      ntf_desc   <= '0;
      ntf_target <= '0;
      ntf_prio   <= '0;
      drop_cnt   <= '0;
      for (int i = 0; i < SRC_N; i++) begin
        as_valid[i] <= 1'b0;
        as_mask[i]  <= 1'b0;
        as_desc[i]  <= '0;
        as_data[i]  <= '0;
      end
      for (int d = 0; d < DESC_N; d++) begin
        d_prio[d] <= 3'd7;
        d_tgt[d]  <= '0;
        d_widx[d] <= '0;
        d_gen[d]  <= 1'b1;
        d_pend[d] <= 1'b0;
      end
      for (int s = 0; s < DESC_N*Q_DEPTH; s++) qmem[s] <= '0;
    end else begin
      ntf_valid <= 1'b0;

      if (cfg_as) begin
        as_valid[cfg_idx] <= cfg_data[0];
        as_mask[cfg_idx]  <= cfg_data[1];
        as_desc[cfg_idx]  <= cfg_data[2 +: DI_W];
        as_data[cfg_idx]  <= cfg_data[2 + DI_W +: DATA_W];
      end

      if (take) begin
        if (routable) begin
          busy   <= 1'b1;
          w_desc <= as_desc[ev_src];
          w_data <= as_data[ev_src];
        end else begin
          drop_cnt <= drop_cnt + 1'b1;
        end
      end

      if (cfg_rearm) d_pend[cfg_di] <= 1'b0;

      if (busy) begin
        busy <= 1'b0;
        qmem[{w_desc, d_widx[w_desc]}] <= {d_gen[w_desc], w_data};
        if (last_slot) begin
          d_widx[w_desc] <= '0;
          d_gen[w_desc]  <= ~d_gen[w_desc];
        end else begin
          d_widx[w_desc] <= d_widx[w_desc] + 1'b1;
        end
        if (!pend_eff) begin
          ntf_valid  <= 1'b1;
          ntf_desc   <= w_desc;
          ntf_target <= d_tgt[w_desc];
          ntf_prio   <= d_prio[w_desc];
        end
        d_pend[w_desc] <= 1'b1;
      end

      if (cfg_ds) begin
        d_prio[cfg_di] <= cfg_data[2:0];
        d_tgt[cfg_di]  <= cfg_data[3 +: TGT_W];
        d_widx[cfg_di] <= '0;
        d_gen[cfg_di]  <= 1'b1;
        d_pend[cfg_di] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/evq_router_chk.sv
module evq_router_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic             ntf_valid,
  input logic [CNT_W-1:0] drop_cnt
);

  assert_stall_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ready |=> ev_ready);

  assert_ntf_follows_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> $past(!ev_ready));

  assert_ntf_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |=> !ntf_valid);

  assert_drop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_cnt) |-> drop_cnt == CNT_W'($past(drop_cnt) + 1'b1));

  assert_drop_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_cnt) |-> $past(ev_valid && ev_ready));

endmodule

bind evq_router evq_router_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ntf_valid(ntf_valid), .drop_cnt(drop_cnt)
);

// File: tb/evq_router_test.sv
module evq_router_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [3:0]  ev_src = '0;
  logic        ev_ready;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [3:0]  cfg_idx = '0;
  logic [19:0] cfg_data = '0;
  logic        ntf_valid;
  logic [1:0]  ntf_desc;
  logic [7:0]  ntf_target;
  logic [2:0]  ntf_prio;
  logic [1:0]  rd_desc = '0;
  logic [1:0]  rd_slot = '0;
  logic [16:0] rd_entry;
  logic [7:0]  drop_cnt;

  evq_router uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src), .ev_ready(ev_ready),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .ntf_valid(ntf_valid), .ntf_desc(ntf_desc), .ntf_target(ntf_target), .ntf_prio(ntf_prio),
    .rd_desc(rd_desc), .rd_slot(rd_slot), .rd_entry(rd_entry), .drop_cnt(drop_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit          m_val [16];
  bit          m_msk [16];
  int          m_dsc [16];
  logic [15:0] m_dat [16];
  int          m_prio [4];
  int          m_tgt  [4];
  int          m_widx [4];
  bit          m_gen  [4];
  bit          m_pend [4];
  logic [16:0] m_q [4][4];
  int          m_drops = 0;
  logic [12:0] exp_q [$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ntf_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected notification", int'({ntf_desc, ntf_target, ntf_prio}), 0);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        chk({ntf_desc, ntf_target, ntf_prio} == e, "R2", "notification desc/target/prio",
            int'({ntf_desc, ntf_target, ntf_prio}), int'(e));
      end
    end
  end

  task automatic cfg(int kind, int idx, logic [19:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_idx = 4'(idx); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_assign(int src, bit v, bit m, int d, logic [15:0] data);
    cfg(0, src, {data, 2'(d), m, v});
    m_val[src] = v; m_msk[src] = m; m_dsc[src] = d; m_dat[src] = data;
  endtask

  task automatic set_desc(int d, int prio, int tgt);
    cfg(1, d, {9'd0, 8'(tgt), 3'(prio)});
    m_prio[d] = prio; m_tgt[d] = tgt; m_widx[d] = 0; m_gen[d] = 1'b1; m_pend[d] = 1'b0;
  endtask

  task automatic rearm(int d);
    cfg(2, d, '0);
    m_pend[d] = 1'b0;
  endtask

  task automatic send(int src, bit rearm_same, bit hold);
    bit ok;
    int d;
    ok = m_val[src] && !m_msk[src];
    d  = m_dsc[src];
    @(negedge clk);
    ev_valid = 1'b1; ev_src = 4'(src);
    @(negedge clk);
    if (!hold) ev_valid = 1'b0;
    if (ok) begin
      chk(ev_ready == 1'b0, "R6", "ready low after accept", int'(ev_ready), 0);
      if (rearm_same) begin
        cfg_we = 1'b1; cfg_kind = 2'd2; cfg_idx = 4'(d); cfg_data = '0;
        m_pend[d] = 1'b0;
      end
      if (!m_pend[d]) exp_q.push_back({2'(d), 8'(m_tgt[d]), 3'(m_prio[d])});
      m_pend[d] = 1'b1;
      m_q[d][m_widx[d]] = {m_gen[d], m_dat[src]};
      if (m_widx[d] == 3) begin m_widx[d] = 0; m_gen[d] = ~m_gen[d]; end
      else m_widx[d]++;
      @(negedge clk);
      ev_valid = 1'b0; cfg_we = 1'b0;
      chk(ev_ready == 1'b1, "R6", "ready back after one stall cycle", int'(ev_ready), 1);
    end else begin
      m_drops++;
      chk(ev_ready == 1'b1, "R5", "ready stays high on drop", int'(ev_ready), 1);
      chk(drop_cnt == 8'(m_drops), "R5", "drop count", int'(drop_cnt), m_drops);
    end
    @(negedge clk);
    chk(exp_q.size() == 0, "R2", "notification delivered", exp_q.size(), 0);
  endtask

  task automatic rd_chk(int d, int s, string req);
    @(negedge clk);
    rd_desc = 2'(d); rd_slot = 2'(s);
    #1;
    chk(rd_entry == m_q[d][s], req, "queue slot", int'(rd_entry), int'(m_q[d][s]));
  endtask

  task automatic rd_all(string req);
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++) rd_chk(d, s, req);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_msk[i] = 0; m_dsc[i] = 0; m_dat[i] = '0; end
    for (int d = 0; d < 4; d++) begin
      m_prio[d] = 7; m_tgt[d] = 0; m_widx[d] = 0; m_gen[d] = 1; m_pend[d] = 0;
      for (int s = 0; s < 4; s++) m_q[d][s] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ev_ready == 1'b1, "R1", "ready after reset", int'(ev_ready), 1);
    chk(ntf_valid == 1'b0, "R1", "no notification after reset", int'(ntf_valid), 0);
    chk(drop_cnt == 8'd0, "R1", "drop count after reset", int'(drop_cnt), 0);
    rd_all("R1");
    send(4, 1'b0, 1'b0);                       // R1: unprogrammed entry is invalid

    set_desc(0, 2, 8'h11);                     // R9
    set_desc(1, 0, 8'h22);
    set_desc(2, 7, 8'h33);
    set_desc(3, 5, 8'h44);
    set_assign(1, 1, 0, 0, 16'hA001);
    set_assign(3, 1, 0, 0, 16'hC003);
    set_assign(2, 1, 0, 1, 16'hB002);
    set_assign(5, 1, 1, 2, 16'h5555);
    set_assign(6, 0, 0, 2, 16'h6666);
    set_assign(7, 1, 0, 3, 16'h7777);

    send(1, 1'b0, 1'b0);                       // R2 R3
    rd_chk(0, 0, "R3");
    send(3, 1'b0, 1'b0);                       // R7 coalesced
    rd_chk(0, 1, "R7");
    send(5, 1'b0, 1'b0);                       // R5 masked
    send(6, 1'b0, 1'b0);                       // R5 invalid
    rd_all("R5");
    rearm(0);                                  // R7 re-arm
    send(1, 1'b0, 1'b0);
    send(3, 1'b0, 1'b0);
    send(1, 1'b0, 1'b0);                       // R4 wrap, gen 0
    rd_chk(0, 0, "R4");
    rd_chk(0, 3, "R4");
    send(3, 1'b1, 1'b0);                       // R8 rearm with write
    send(1, 1'b0, 1'b0);                       // R8 pending ended set: coalesced
    rd_all("R8");
    send(2, 1'b0, 1'b0);                       // R2 prio 0
    send(7, 1'b0, 1'b1);                       // R6 held input taken once
    rd_all("R6");
    send(2, 1'b0, 1'b0);                       // R7 d1 still pending
    set_desc(0, 4, 8'h55);                     // R9 reprogram resets queue state
    send(3, 1'b0, 1'b0);
    rd_chk(0, 0, "R9");
    rd_all("R3");
    chk(drop_cnt == 8'(m_drops), "R5", "final drop count", int'(drop_cnt), m_drops);
    report();
  end
endmodule